// File: doc/BRIEF.md
# Check Node Unit with Time-Redundant Sign Voting

This block performs one check node update of a soft-decision message-passing decoder for low-density parity-check codes. It takes one signed log-likelihood message from each of its `DEG` connected bit nodes and returns one extrinsic message per edge. Each output leaves out the contribution of the edge it is sent back on. The magnitude uses the min-sum approximation: the smallest input magnitude among the other edges. It is computed once, from the first and second minimum, and is not protected. Any error in it is left for later decoder iterations to wash out.

The sign is the part that matters most, so it is protected by repetition in time. The same exclusive-OR datapath is run `REPS` times (five by default), one pass per cycle. Each edge keeps the result of every pass, and a majority voter picks the final sign. A fault-injection pair of inputs can invert chosen edges' sign results in chosen passes. A test can then show that a minority of corrupted passes is outvoted.

Input and output use valid/ready handshakes. A message set is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so `in_valid` is ignored while a set is in flight. A result is presented with `out_valid` and held, unchanged, until a rising edge with `out_ready` high consumes it. Only after that does the unit accept new input.

Top module: `cnu_tr_vote`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every output message is zero.
- R2: A set is accepted on a rising edge with `in_valid` and `in_ready` both high. From the next cycle `in_ready` stays 0 until the result is consumed, and any `in_valid` or `in_msgs` activity meanwhile has no effect on the result.
- R3: `out_valid` rises right after the (REPS+1)-th rising edge that follows the accepting edge: one edge per sign pass, then one vote edge.
- R4: With no fault injected, the sign of output message i is the exclusive-OR of the sign bits (bit W-1) of all input messages except message i.
- R5: The magnitude of output i is the minimum of |input j| over all j ≠ i. Input values are W-bit two's complement. The most negative code counts as magnitude 2^(W-1)-1. Ties between equal minima give that value to every edge.
- R6: Output i is the magnitude when the voted sign is 0 and its two's complement negation when it is 1. No output ever carries the most negative code.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_msgs` stays stable. After the consuming edge, `out_valid` is 0 and `in_ready` is 1.
- R8: Bit k of `flt_rep_mask` together with bit i of `flt_edge_mask` inverts edge i's sign result in pass k. When at most REPS/2 passes are inverted, the output equals the fault-free output.
- R9: The voter sets a sign to 1 when at least REPS/2+1 of the REPS pass results are 1. So inverting an edge in a majority of passes inverts that edge's sign and leaves its magnitude alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message set is valid |
| in_ready | output | 1 | Unit is idle and can accept a set |
| in_msgs | input | DEG*W | Bit-to-check messages; edge i at bits [i*W +: W] |
| flt_rep_mask | input | REPS | Passes in which the fault is applied |
| flt_edge_mask | input | DEG | Edges whose sign result is inverted in the selected passes |
| out_valid | output | 1 | Result is valid and held |
| out_ready | input | 1 | Consumer takes the result |
| out_msgs | output | DEG*W | Check-to-bit messages; edge i at bits [i*W +: W] |

## Verification
The properties assume a synchronous active-low reset and do not require `out_ready` to follow any pattern. They also assume the fault masks are stable from the accepting edge until the vote, because the result depends on the mask values seen in each pass. The stimulus sets the masks together with the input set, holds them through the hold phase and clears them only after the result is consumed. It keeps `in_valid` high with altered data during busy cycles to exercise the ignore rule, and it drops `in_valid` before the unit returns to idle, so no unintended set is accepted.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_VOTE = 2'd2,
    ST_HOLD = 2'd3
  } cnu_state_t;
endpackage

// File: rtl/cnu_min_sum.sv
// Saturating absolute value per edge, then first/second minimum search.
module cnu_min_sum #(
  parameter int DEG = 6,
  parameter int W   = 8
) (
  input  logic [DEG*W-1:0]     msgs,
  output logic [DEG*(W-1)-1:0] mags
);
  localparam int MW = W - 1;
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;

  logic [MW-1:0] absv [DEG];

  for (genvar g = 0; g < DEG; g++) begin : g_abs
    logic [W-1:0] x;
    logic [W-1:0] neg;
    assign x   = msgs[g*W +: W];
    assign neg = ~x + 1'b1;
    always_comb begin
      if (!x[W-1])       absv[g] = x[MW-1:0];
      else if (neg[W-1]) absv[g] = {MW{1'b1}};
      else               absv[g] = neg[MW-1:0];
    end
  end

  logic [MW-1:0] min1, min2;
  logic [IW-1:0] idx1;

  always_comb begin
    min1 = {MW{1'b1}};
    min2 = {MW{1'b1}};
    idx1 = '0;
    for (int i = 0; i < DEG; i++) begin
      if (absv[i] < min1) begin
        min2 = min1;
        min1 = absv[i];
        idx1 = IW'(i);
      end else if (absv[i] < min2) begin
        min2 = absv[i];
      end
    end
  end

  for (genvar g = 0; g < DEG; g++) begin : g_sel
    assign mags[g*MW +: MW] = (idx1 == IW'(g)) ? min2 : min1;
  end
endmodule

// File: rtl/cnu_sign_pass.sv
// One pass of the extrinsic sign computation with optional per-edge inversion.
module cnu_sign_pass #(
  parameter int DEG = 6
) (
  input  logic [DEG-1:0] signs,
  input  logic [DEG-1:0] flip,
  output logic [DEG-1:0] ext
);
  logic parity;
  assign parity = ^signs;

  for (genvar g = 0; g < DEG; g++) begin : g_ext
    assign ext[g] = parity ^ signs[g] ^ flip[g];
  end
endmodule

// File: rtl/cnu_maj_vote.sv
// Majority decision over REPS pass results.
module cnu_maj_vote #(
  parameter int REPS = 5
) (
  input  logic [REPS-1:0] samples,
  output logic            vote
);
  localparam int NEED = REPS / 2 + 1;
  assign vote = ($countones(samples) >= NEED);
endmodule

// File: rtl/cnu_tr_vote.sv
module cnu_tr_vote #(
  parameter int DEG  = 6,
  parameter int W    = 8,
  parameter int REPS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DEG*W-1:0] in_msgs,
  input  logic [REPS-1:0]  flt_rep_mask,
  input  logic [DEG-1:0]   flt_edge_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DEG*W-1:0] out_msgs
);
  import cnu_pkg::*;

  localparam int MW = W - 1;
  localparam int CW = (REPS > 1) ? $clog2(REPS) : 1;

  cnu_state_t state;
  logic [CW-1:0]         rep_cnt;
  logic [DEG-1:0]        sign_q;
  logic [DEG*MW-1:0]     mag_q;
  logic [DEG-1:0][REPS-1:0] hist_q;

  logic                  accept;
  logic [DEG*MW-1:0]     mag_nxt;
  logic [DEG-1:0]        in_signs;
  logic [DEG-1:0]        flip_cur;
  logic [DEG-1:0]        pass_ext;
  logic [DEG-1:0]        voted;
  logic [DEG*W-1:0]      out_nxt;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < DEG; g++) begin : g_in_sign
    assign in_signs[g] = in_msgs[g*W + W - 1];
  end

  cnu_min_sum #(.DEG(DEG), .W(W)) u_min (
    .msgs (in_msgs),
    .mags (mag_nxt)
  );

  assign flip_cur = flt_edge_mask & {DEG{flt_rep_mask[rep_cnt]}};

  cnu_sign_pass #(.DEG(DEG)) u_pass (
    .signs (sign_q),
    .flip  (flip_cur),
    .ext   (pass_ext)
  );

  for (genvar g = 0; g < DEG; g++) begin : g_vote
    logic [W-1:0] pos;
    cnu_maj_vote #(.REPS(REPS)) u_vote (
      .samples (hist_q[g]),
      .vote    (voted[g])
    );
    assign pos = {1'b0, mag_q[g*MW +: MW]};
    assign out_nxt[g*W +: W] = voted[g] ? (~pos + 1'b1) : pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rep_cnt   <= '0;
      sign_q    <= '0;
      mag_q     <= '0;
      hist_q    <= '0;
      out_valid <= 1'b0;
      out_msgs  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sign_q  <= in_signs;
            mag_q   <= mag_nxt;
            rep_cnt <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          for (int i = 0; i < DEG; i++) begin
            hist_q[i][rep_cnt] <= pass_ext[i];
          end
          if (rep_cnt == CW'(REPS - 1)) begin
            state <= ST_VOTE;
          end else begin
            rep_cnt <= rep_cnt + 1'b1;
          end
        end
        ST_VOTE: begin
          out_msgs  <= out_nxt;
          out_valid <= 1'b1;
          state     <= ST_HOLD;
        end
        default: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cnu_tr_vote_chk.sv
module cnu_tr_vote_chk #(
  parameter int DEG  = 6,
  parameter int W    = 8,
  parameter int REPS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DEG*W-1:0] out_msgs
);
  localparam int LAT = REPS + 2;

  logic [7:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      lat_cnt <= '0;
    else if (in_valid && in_ready)   lat_cnt <= 8'd1;
    else if (out_valid && out_ready) lat_cnt <= '0;
    else if (lat_cnt != '0 && !out_valid) lat_cnt <= lat_cnt + 8'd1;
  end

  logic no_min_code;
  always_comb begin
    no_min_code = 1'b1;
    for (int i = 0; i < DEG; i++) begin
      if (out_msgs[i*W +: W] == {1'b1, {(W-1){1'b0}}}) no_min_code = 1'b0;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_VOTE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 8'(LAT))); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msgs))); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R7
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> no_min_code); // R6
endmodule

bind cnu_tr_vote cnu_tr_vote_chk #(.DEG(DEG), .W(W), .REPS(REPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_msgs  (out_msgs)
);

// File: tb/cnu_tr_vote_test.sv
`timescale 1ns/1ps
module cnu_tr_vote_test;
  localparam int DEG  = 6;
  localparam int W    = 8;
  localparam int REPS = 5;
  localparam int MAXM = (1 << (W - 1)) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [DEG*W-1:0] in_msgs = '0;
  logic [REPS-1:0]  flt_rep_mask = '0;
  logic [DEG-1:0]   flt_edge_mask = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [DEG*W-1:0] out_msgs;

  always #5 clk = ~clk;

  cnu_tr_vote #(.DEG(DEG), .W(W), .REPS(REPS)) uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_msgs (in_msgs), .flt_rep_mask (flt_rep_mask), .flt_edge_mask (flt_edge_mask),
    .out_valid (out_valid), .out_ready (out_ready), .out_msgs (out_msgs)
  );

  typedef struct {
    logic [DEG*W-1:0] v;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string tag, input logic [DEG*W-1:0] act,
                       input logic [DEG*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DEG*W-1:0] model(input logic [DEG*W-1:0] m,
                                             input logic [REPS-1:0] rm,
                                             input logic [DEG-1:0] em);
    logic [DEG*W-1:0] r;
    for (int i = 0; i < DEG; i++) begin
      int mn;
      int val;
      bit s;
      mn = MAXM;
      s  = 0;
      for (int j = 0; j < DEG; j++) begin
        if (j != i) begin
          int x;
          int a;
          x = int'($signed(m[j*W +: W]));
          a = (x < 0) ? -x : x;
          if (a > MAXM) a = MAXM;
          if (a < mn) mn = a;
          s ^= m[j*W + W - 1];
        end
      end
      if (em[i] && ($countones(rm) >= REPS / 2 + 1)) s ^= 1'b1;
      val = s ? -mn : mn;
      r[i*W +: W] = val[W-1:0];
    end
    return r;
  endfunction

  // Monitor: compare every consumed result against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected result", out_msgs, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_msgs === e.v, e.tag, out_msgs, e.v);
      end
    end
  end

  task automatic run_vec(input logic [DEG*W-1:0] m, input logic [REPS-1:0] rm,
                         input logic [DEG-1:0] em, input int hold, input string tag);
    exp_t it;
    logic [DEG*W-1:0] snap;
    bit ov5;
    bit stable_ok;
    it.v   = model(m, rm, em);
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    in_msgs = m; in_valid = 1'b1; flt_rep_mask = rm; flt_edge_mask = em;
    while (!in_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;               // accepted on this edge
    in_msgs = ~m;                     // R2: busy-time activity must be ignored
    check(!in_ready, "R2 in_ready low after accept", {{(DEG*W-1){1'b0}}, in_ready}, '0);
    repeat (REPS) begin @(posedge clk); #1; end
    ov5 = out_valid;
    in_valid = 1'b0;
    @(posedge clk); #1;
    check(!ov5 && out_valid, "R3 latency", {{(DEG*W-1){1'b0}}, out_valid},
          {{(DEG*W-1){1'b0}}, 1'b1});
    snap = out_msgs;
    stable_ok = 1;
    repeat (hold) begin
      @(posedge clk); #1;
      if (!out_valid || out_msgs !== snap) stable_ok = 0;
    end
    check(stable_ok, "R7 hold stable", out_msgs, snap);
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R7 release", {{(DEG*W-2){1'b0}}, in_ready, out_valid},
          {{(DEG*W-2){1'b0}}, 2'b10});
    flt_rep_mask = '0; flt_edge_mask = '0;
  endtask

  function automatic logic [DEG*W-1:0] pack6(input int a0, input int a1, input int a2,
                                             input int a3, input int a4, input int a5);
    logic [DEG*W-1:0] r;
    int t [6];
    t = '{a0, a1, a2, a3, a4, a5};
    for (int i = 0; i < DEG; i++) r[i*W +: W] = t[i][W-1:0];
    return r;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0 && in_ready === 1'b1 && out_msgs === '0,
          "R1 reset state", out_msgs, '0);
    rst_n = 1'b1;
    #1;
    check(out_msgs === '0, "R1 zero messages after reset", out_msgs, '0);

    run_vec(pack6(10, 20, 30, 40, 50, 60), '0, '0, 0, "R4 R5 all positive");
    run_vec(pack6(-10, 20, -30, 40, 5, -60), '0, '0, 2, "R4 R6 mixed signs");
    run_vec(pack6(-128, 100, 127, -128, 90, 100), '0, '0, 1, "R5 R6 saturation");
    run_vec(pack6(7, -7, 30, 40, 50, 60), '0, '0, 3, "R5 tied minimum");
    run_vec(pack6(0, -1, 3, -3, 0, 9), '0, '0, 0, "R5 R6 zero magnitude");
    run_vec(pack6(-5, -6, -7, -8, -9, -10), '0, '0, 0, "R4 all negative");

    run_vec(pack6(12, -33, 44, -55, 66, -77), 5'b00001, 6'b111111, 1, "R8 one pass hit");
    run_vec(pack6(12, -33, 44, -55, 66, -77), 5'b10100, 6'b101101, 0, "R8 two passes hit");
    run_vec(pack6(12, -33, 44, -55, 66, -77), 5'b01011, 6'b000110, 2, "R9 three passes hit");
    run_vec(pack6(-90, 33, 4, 55, -2, 77), 5'b11111, 6'b100001, 0, "R9 all passes hit");
    run_vec(pack6(-90, 33, 4, 55, -2, 77), 5'b11100, 6'b010000, 0, "R9 upper majority");

    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 12; k++) begin
      logic [DEG*W-1:0] m;
      for (int i = 0; i < DEG; i++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        m[i*W +: W] = lf[W-1:0];
      end
      run_vec(m, lf[12:8], lf[21:16], k % 3, "R4 R5 R6 R8 R9 sweep");
    end

    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R2 every accepted set returned", DEG*W'(sb.size()), '0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule